// File: doc/BRIEF.md
# Crosstalk-Free Bus Segment Unpacker

This block sits on the receive end of a wide on-chip bus whose wires are arranged so that adjacent channels never switch against each other. Four 32-bit channels share a 135-bit bus. Each channel is followed by a short group of spacer wires, and these wires also say whether the channel carries a real word or an idle filler. The sender places words on whichever channels are free of crosstalk in a given cycle, so the valid words can land on any subset of channel positions.

Every clock the unpacker registers the bus and classifies each channel from its spacer bits. It packs the real words into the low slots of a multi-word push toward a prefetch queue. The words keep their channel order. The block drives a word count and a push strobe, and it raises a protocol-error flag when a spacer code is illegal. A stall output is derived from the free-space count the queue reports. It tells the sender to hold off whenever fewer than four entries are free.

Top module: `xtbus_unpacker`

## Requirements
- R1: While `rst` is high at a rising edge, the registered outputs become zero: `push_vld_o`, `push_cnt_o`, `push_data_o` and `proto_err_o`.
- R2: Channel k (k = 0..3, k=0 first) occupies bus bits [103-34k +: 32]. Channels 0–2 are classified by the two bits just below them, {bus[lsb-1], bus[lsb-2]}. The value 2'b10 means data and 2'b00 means idle. Channel 3 is classified by bus[0] alone: 1 means data and 0 means idle.
- R3: Data words are placed in ascending channel order. The first data word goes into `push_data_o[31:0]`, the next into [63:32], and so on. Idle channels leave no gap.
- R4: `push_cnt_o` equals the number of data channels in the sampled bus, from 0 to 4.
- R5: Every output slot at or above `push_cnt_o` reads zero.
- R6: For channels 0–2, a spacer code of 2'b01 or 2'b11 sets `proto_err_o` for that cycle, and that channel's word is dropped. The other channels are still delivered.
- R7: `stall_o` is high in the same cycle exactly when `q_room_i` is below 4.
- R8: `push_vld_o` is high exactly when `push_cnt_o` is nonzero.
- R9: A bus value sampled at a rising edge appears on the outputs right after that edge. The outputs then hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_i | input | 135 | Encoded bus: four channels plus spacer wires |
| q_room_i | input | 8 | Free entries reported by the queue |
| stall_o | output | 1 | Sender must hold off (room below 4) |
| push_vld_o | output | 1 | At least one word is pushed this cycle |
| push_cnt_o | output | 3 | Number of words pushed (0–4) |
| push_data_o | output | 128 | Compacted words; slot 0 in the low bits |
| proto_err_o | output | 1 | Illegal spacer code seen in the sampled bus |

## Verification
The push-gating assertion assumes the sender obeys `stall_o`. Whenever a push appears, the queue must have reported at least four free entries in the cycle the bus was sampled. The stimulus honours this rule: it lowers `q_room_i` below 4 only while it drives an all-idle bus, and it restores room before it sends data again. The other assertions rely only on the count and slot contents. They hold for any bus pattern, including the illegal spacer codes that the stimulus injects on purpose.

// File: rtl/xtbus_pkg.sv
package xtbus_pkg;

    localparam int CH_N   = 4;
    localparam int CH_W   = 32;
    localparam int STRIDE = CH_W + 2;
    localparam int BUS_W  = CH_N * CH_W + 2 * (CH_N - 1) + 1;
    localparam int CNT_W  = $clog2(CH_N + 1);
    localparam int OUT_W  = CH_N * CH_W;

    typedef enum logic [1:0] {
        SEG_IDLE = 2'd0,
        SEG_DATA = 2'd1,
        SEG_BAD  = 2'd2
    } seg_kind_e;

    typedef struct packed {
        seg_kind_e         kind;
        logic [CH_W-1:0]   word;
    } seg_t;

    typedef struct packed {
        logic              vld;
        logic [CNT_W-1:0]  cnt;
        logic [OUT_W-1:0]  data;
        logic              err;
    } push_t;

    // Lowest bus bit of channel k; channel 0 sits at the top of the bus.
    function automatic int ch_lsb(input int k);
        return BUS_W - k * STRIDE - CH_W;
    endfunction

    // Bits belonging to slots below the count.
    function automatic logic [OUT_W-1:0] used_mask(input logic [CNT_W-1:0] n);
        logic [OUT_W-1:0] m;
        m = '0;
        for (int s = 0; s < CH_N; s++) begin
            if (s < int'(n)) m[s*CH_W +: CH_W] = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/xtbus_seg_decode.sv
module xtbus_seg_decode
    import xtbus_pkg::*;
#(
    parameter int N = CH_N,
    parameter int W = CH_W,
    parameter int BW = BUS_W
) (
    input  logic [BW-1:0]  bus_i,
    output seg_t [N-1:0]   seg_o
);

    for (genvar k = 0; k < N; k++) begin : g_ch
        localparam int LSB = BW - k * (W + 2) - W;
        assign seg_o[k].word = bus_i[LSB +: W];
        if (k < N - 1) begin : g_pair
            logic [1:0] code;
            assign code = {bus_i[LSB-1], bus_i[LSB-2]};
            always_comb begin
                case (code)
                    2'b10:   seg_o[k].kind = SEG_DATA;
                    2'b00:   seg_o[k].kind = SEG_IDLE;
                    default: seg_o[k].kind = SEG_BAD;
                endcase
            end
        end else begin : g_single
            assign seg_o[k].kind = bus_i[LSB-1] ? SEG_DATA : SEG_IDLE;
        end
    end

endmodule

// File: rtl/xtbus_compact.sv
module xtbus_compact
    import xtbus_pkg::*;
#(
    parameter int N = CH_N,
    parameter int W = CH_W,
    parameter int CW = CNT_W
) (
    input  seg_t [N-1:0]   seg_i,
    output logic [N*W-1:0] words_o,
    output logic [CW-1:0]  cnt_o,
    output logic           err_o
);

    // Slot each channel would land in: number of data channels ahead of it.
    logic [CW-1:0] pos [N];

    always_comb begin
        logic [CW-1:0] run;
        run = '0;
        for (int c = 0; c < N; c++) begin
            pos[c] = run;
            if (seg_i[c].kind == SEG_DATA) run = run + 1'b1;
        end
        cnt_o = run;
    end

    always_comb begin
        words_o = '0;
        for (int s = 0; s < N; s++) begin
            for (int c = s; c < N; c++) begin
                if (seg_i[c].kind == SEG_DATA && int'(pos[c]) == s)
                    words_o[s*W +: W] = seg_i[c].word;
            end
        end
    end

    always_comb begin
        err_o = 1'b0;
        for (int c = 0; c < N; c++) begin
            if (seg_i[c].kind == SEG_BAD) err_o = 1'b1;
        end
    end

endmodule

// File: rtl/xtbus_unpacker.sv
module xtbus_unpacker
    import xtbus_pkg::*;
#(
    parameter int ROOM_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BUS_W-1:0]   bus_i,
    input  logic [ROOM_W-1:0]  q_room_i,
    output logic               stall_o,
    output logic               push_vld_o,
    output logic [CNT_W-1:0]   push_cnt_o,
    output logic [OUT_W-1:0]   push_data_o,
    output logic               proto_err_o
);

    localparam logic [ROOM_W-1:0] NEED = ROOM_W'(CH_N);

    seg_t [CH_N-1:0]   segs;
    logic [OUT_W-1:0]  words_c;
    logic [CNT_W-1:0]  cnt_c;
    logic              err_c;
    push_t             out_q;

    xtbus_seg_decode #(.N(CH_N), .W(CH_W), .BW(BUS_W)) u_dec (
        .bus_i (bus_i),
        .seg_o (segs)
    );

    xtbus_compact #(.N(CH_N), .W(CH_W), .CW(CNT_W)) u_pack (
        .seg_i   (segs),
        .words_o (words_c),
        .cnt_o   (cnt_c),
        .err_o   (err_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld  <= (cnt_c != '0);
            out_q.cnt  <= cnt_c;
            out_q.data <= words_c;
            out_q.err  <= err_c;
        end
    end

    assign stall_o     = (q_room_i < NEED);
    assign push_vld_o  = out_q.vld;
    assign push_cnt_o  = out_q.cnt;
    assign push_data_o = out_q.data;
    assign proto_err_o = out_q.err;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        push_cnt_o <= CNT_W'(CH_N));                                      // R4
    AST_SLOT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (push_data_o & ~used_mask(push_cnt_o)) == '0);                    // R5
    AST_ERR_DROPS: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |-> (push_cnt_o < CNT_W'(CH_N)));                     // R6
    AST_NO_PUSH_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
        push_vld_o |-> $past(!stall_o));                                  // R7
    AST_VLD_MATCHES_CNT: assert property (@(posedge clk) disable iff (rst)
        push_vld_o == (push_cnt_o != '0));                                // R8

endmodule

// File: tb/xtbus_unpacker_tb.sv
module xtbus_unpacker_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic [134:0] bus;
    logic [7:0]   room;
    logic         stall;
    logic         vld;
    logic [2:0]   cnt;
    logic [127:0] data;
    logic         perr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xtbus_unpacker dut_i (
        .clk(clk), .rst(rst), .bus_i(bus), .q_room_i(room),
        .stall_o(stall), .push_vld_o(vld), .push_cnt_o(cnt),
        .push_data_o(data), .proto_err_o(perr)
    );

    // codes: channel0 in [7:6] ... channel3 in [1:0]; order: slot0 channel in [7:6]
    typedef struct packed {
        logic [7:0] codes;
        logic [2:0] cnt;
        logic       err;
        logic [7:0] order;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'b00000000, 3'd0, 1'b0, 8'b00000000},
        '{8'b10101010, 3'd4, 1'b0, 8'b00011011},
        '{8'b10000000, 3'd1, 1'b0, 8'b00000000},
        '{8'b00000010, 3'd1, 1'b0, 8'b11000000},
        '{8'b00100010, 3'd2, 1'b0, 8'b01110000},
        '{8'b10001000, 3'd2, 1'b0, 8'b00100000},
        '{8'b00101010, 3'd3, 1'b0, 8'b01101100},
        '{8'b10100000, 3'd2, 1'b0, 8'b00010000},
        '{8'b01100010, 3'd2, 1'b1, 8'b01110000},
        '{8'b10111000, 3'd2, 1'b1, 8'b00100000},
        '{8'b11011110, 3'd1, 1'b1, 8'b11000000},
        '{8'b00001000, 3'd1, 1'b0, 8'b10000000}
    };

    function automatic logic [31:0] mk_word(input int c, input int i);
        return {8'hA0 + 8'(c), 8'(i), 16'h1234 + 16'(c * 7 + i * 3)};
    endfunction

    function automatic logic [134:0] mk_bus(input logic [7:0] codes, input int i);
        logic [134:0] b;
        b = '0;
        for (int c = 0; c < 4; c++) begin
            int lsb;
            logic [1:0] cd;
            lsb = 103 - 34 * c;
            cd = codes[7-2*c -: 2];
            b[lsb +: 32] = mk_word(c, i);
            if (c < 3) begin
                b[lsb-1] = cd[1];
                b[lsb-2] = cd[0];
            end else begin
                b[0] = cd[1];
            end
        end
        return b;
    endfunction

    function automatic logic [127:0] exp_data(input vec_t v, input int i);
        logic [127:0] d;
        d = '0;
        for (int s = 0; s < 4; s++) begin
            if (s < int'(v.cnt)) d[s*32 +: 32] = mk_word(int'(v.order[7-2*s -: 2]), i);
        end
        return d;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [134:0] b);
        @(negedge clk);
        bus = b;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst  = 1'b1;
        room = 8'd100;
        bus  = mk_bus(8'b10101010, 1);
        repeat (3) @(posedge clk);
        #2;
        // R1: reset holds outputs at zero even with data on the bus
        chk("R1 vld", 128'(vld), 128'(0));
        chk("R1 cnt", 128'(cnt), 128'(0));
        chk("R1 data", data, 128'(0));
        chk("R1 err", 128'(perr), 128'(0));
        @(negedge clk);
        rst = 1'b0;
        bus = '0;

        // Table walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            send(mk_bus(VECS[i].codes, i));
            chk("R4 count", 128'(cnt), 128'(VECS[i].cnt));
            chk("R3/R5 data", data, exp_data(VECS[i], i));
            chk("R6 err", 128'(perr), 128'(VECS[i].err));
            chk("R8 vld", 128'(vld), 128'(VECS[i].cnt != 0));
        end

        // R2: channel3 uses only bus[0]; bit 1 is channel3's own word LSB
        send(mk_bus(8'b00000000, 40) | 135'(1));
        chk("R2 last-ch bit0", 128'(cnt), 128'(1));
        chk("R2 last-ch word", data, 128'(mk_word(3, 40)));

        // R9: output holds before the edge, changes right after it
        send(mk_bus(8'b10000000, 50));
        @(negedge clk);
        bus = mk_bus(8'b10101010, 51);
        #1;
        chk("R9 hold", data, 128'(mk_word(0, 50)));
        @(posedge clk);
        #2;
        chk("R9 update", 128'(cnt), 128'(4));

        // R7: stall threshold, combinational; idle bus while room is short
        @(negedge clk);
        bus = '0;
        room = 8'd3;
        #1;
        chk("R7 room3", 128'(stall), 128'(1));
        room = 8'd0;
        #1;
        chk("R7 room0", 128'(stall), 128'(1));
        room = 8'd4;
        #1;
        chk("R7 room4", 128'(stall), 128'(0));
        room = 8'd255;
        #1;
        chk("R7 room255", 128'(stall), 128'(0));
        @(posedge clk);
        #2;
        chk("R4 idle", 128'(cnt), 128'(0));

        // R1: reset mid-stream clears outputs
        send(mk_bus(8'b10101010, 60));
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk("R1 mid reset", 128'(cnt), 128'(0));
        chk("R1 mid data", data, 128'(0));
        @(negedge clk);
        rst = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule